// File: doc/BRIEF.md
# Dual-Role USB Global Interrupt Status Register

This block holds the global interrupt status word of a dual-role USB controller. Single-cycle event pulses from the device-side and host-side logic are caught in sticky status bits. Software clears a sticky bit by writing a one to its position. Live FIFO-level flags sit in the same word. They follow their source conditions, and writes do not change them. The word also reports whether the controller is in host mode or device mode.

Some events only make sense in one role. A host-only event pulse is dropped while the controller is in device mode, and a device-only pulse is dropped in host mode. A bit that belongs to the other role reads as zero. The periodic transmit-empty flag combines two conditions: the fill level of the periodic transmit FIFO against a selectable threshold (half or fully empty), and free space in the periodic request queue. A registered interrupt line is raised when any visible status bit is also enabled in a mask input that comes from outside the block.

Top module: `usb_gint_status`

## Requirements
- R1: After reset the word reads 0x0400_0020 on the first read (bit 26 and bit 5 set, all other bits 0), and `irq` is 0.
- R2: A sticky bit (31 wake, 30 session, 29 disconnect, 28 connector-ID change, 12 bus reset, 3 frame start) is set on the clock edge that samples its event pulse. It then stays set until cleared. Writing 0 to a bit leaves it unchanged.
- R3: A write to offset 0x014 clears exactly the sticky bits whose `reg_wdata` bit is 1. A write to any other offset changes nothing.
- R4: When an event pulse and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R5: Bit 29 (disconnect) records events only while `host_mode` is 1. It reads 0 while the registered mode is device.
- R6: Bit 12 (bus reset) records events only while `host_mode` is 0. It reads 0 while the registered mode is host.
- R7: Bits 31, 30, 28 and 3 record their events in either mode.
- R8: Bit 26 is registered from this condition: `host_mode`, and `ptx_q_free` is nonzero, and `ptx_free_words` reaches the threshold. The threshold is PTX_DEPTH when `ptx_lvl_full` is 1 and PTX_DEPTH/2 when it is 0.
- R9: Bit 5 is registered from `np_tx_empty` and bit 4 from `rx_nonempty`. Writes to either bit have no effect.
- R10: Bit 0 is registered from `host_mode`, with 1 meaning host. Bit 27 and every undefined bit read 0.
- R11: `irq` is registered. It is 1 one cycle after the visible status word ANDed with `irq_mask` is nonzero, and 0 otherwise.
- R12: `reg_rdata` carries the visible word one cycle after a read to offset 0x014. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | Current role: 1 for host, 0 for device |
| wake_evt | input | 1 | Resume or remote-wakeup pulse |
| sess_evt | input | 1 | Session request or VBUS-valid pulse |
| disc_evt | input | 1 | Disconnect pulse (host only) |
| cid_chg_evt | input | 1 | Connector ID change pulse |
| sof_evt | input | 1 | Frame start pulse |
| bus_rst_evt | input | 1 | Bus reset pulse (device only) |
| ptx_free_words | input | FREE_W | Free words in the periodic transmit FIFO |
| ptx_q_free | input | QF_W | Free entries in the periodic request queue |
| ptx_lvl_full | input | 1 | Empty threshold select: 1 for fully empty, 0 for half empty |
| np_tx_empty | input | 1 | Non-periodic transmit FIFO empty level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| irq_mask | input | 32 | Per-bit interrupt enable |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data (ones clear sticky bits) |
| reg_rdata | output | 32 | Read data, one cycle latency |
| irq | output | 1 | Registered combined interrupt |

## Verification
An event pulse sampled at one edge shows in the status word right after that edge. A read issued in the next cycle returns it one cycle later, and `irq` follows the visible word one cycle after the word changes. So an event reaches `irq` two edges after its pulse. The bench keeps a mirror of the word that updates on the same edges from the same inputs. It compares `reg_rdata` and `irq` at every falling edge. Directed reads are issued only once a stimulus has had its edge, so each explicit value is sampled in the cycle it becomes valid.

// File: rtl/usb_gint_pkg.sv
package usb_gint_pkg;

  localparam int unsigned GS_W = 32;

  localparam int unsigned B_MODE   = 0;
  localparam int unsigned B_SOF    = 3;
  localparam int unsigned B_RXLVL  = 4;
  localparam int unsigned B_NPTXE  = 5;
  localparam int unsigned B_BUSRST = 12;
  localparam int unsigned B_PTXE   = 26;
  localparam int unsigned B_CIDCHG = 28;
  localparam int unsigned B_DISC   = 29;
  localparam int unsigned B_SESS   = 30;
  localparam int unsigned B_WAKE   = 31;

  localparam logic [GS_W-1:0] STICKY_MASK =
    (32'h1 << B_WAKE) | (32'h1 << B_SESS) | (32'h1 << B_DISC) |
    (32'h1 << B_CIDCHG) | (32'h1 << B_BUSRST) | (32'h1 << B_SOF);
  localparam logic [GS_W-1:0] HOST_ONLY_MASK = 32'h1 << B_DISC;
  localparam logic [GS_W-1:0] DEV_ONLY_MASK  = 32'h1 << B_BUSRST;
  localparam logic [GS_W-1:0] LIVE_MASK =
    (32'h1 << B_PTXE) | (32'h1 << B_NPTXE) | (32'h1 << B_RXLVL) | (32'h1 << B_MODE);
  localparam logic [GS_W-1:0] DEFINED_MASK = STICKY_MASK | LIVE_MASK;
  localparam logic [GS_W-1:0] RESET_WORD = 32'h0400_0020;

  // Periodic TX empty threshold: queue must have room, FIFO must be empty enough.
  function automatic logic ptx_thr_met(input int unsigned free_words,
                                       input int unsigned depth,
                                       input int unsigned q_free,
                                       input logic        need_full);
    logic lvl_ok;
    lvl_ok = need_full ? (free_words >= depth) : ((2 * free_words) >= depth);
    return (q_free != 0) && lvl_ok;
  endfunction

  // Hide the bits that belong to the other role.
  function automatic logic [GS_W-1:0] role_view(input logic [GS_W-1:0] st,
                                                input logic            is_host);
    return st & ~(is_host ? DEV_ONLY_MASK : HOST_ONLY_MASK);
  endfunction

endpackage

// File: rtl/gint_sticky_bit.sv
module gint_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Set takes priority so an event coinciding with a clear is kept.
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/gint_live_flags.sv
module gint_live_flags import usb_gint_pkg::*; #(
  parameter int unsigned PTX_DEPTH = 16,
  parameter int unsigned PQ_DEPTH  = 4,
  parameter int unsigned FREE_W    = $clog2(PTX_DEPTH + 1),
  parameter int unsigned QF_W      = $clog2(PQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic [FREE_W-1:0] ptx_free_words,
  input  logic [QF_W-1:0]   ptx_q_free,
  input  logic              ptx_lvl_full,
  input  logic              np_tx_empty,
  input  logic              rx_nonempty,
  output logic              ptx_hit_o,
  output logic              ptxe_q,
  output logic              nptxe_q,
  output logic              rxlvl_q,
  output logic              mode_q
);
  assign ptx_hit_o = host_mode &&
    ptx_thr_met(32'(ptx_free_words), PTX_DEPTH, 32'(ptx_q_free), ptx_lvl_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptxe_q  <= RESET_WORD[B_PTXE];
      nptxe_q <= RESET_WORD[B_NPTXE];
      rxlvl_q <= RESET_WORD[B_RXLVL];
      mode_q  <= RESET_WORD[B_MODE];
    end else begin
      ptxe_q  <= ptx_hit_o;
      nptxe_q <= np_tx_empty;
      rxlvl_q <= rx_nonempty;
      mode_q  <= host_mode;
    end
  end
endmodule

// File: rtl/gint_bus_port.sv
module gint_bus_port import usb_gint_pkg::*; #(
  parameter int unsigned           ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]     REG_OFFSET = 'h014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GS_W-1:0]   reg_wdata,
  input  logic [GS_W-1:0]   view_i,
  output logic [GS_W-1:0]   clr_o,
  output logic [GS_W-1:0]   rdata_o
);
  logic hit;
  assign hit   = reg_sel && (reg_addr == REG_OFFSET);
  assign clr_o = (hit && reg_wr) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)              rdata_o <= '0;
    else if (hit && !reg_wr) rdata_o <= view_i;
    else                     rdata_o <= '0;
  end
endmodule

// File: rtl/usb_gint_status.sv
module usb_gint_status import usb_gint_pkg::*; #(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h014,
  parameter int unsigned       PTX_DEPTH  = 16,
  parameter int unsigned       PQ_DEPTH   = 4,
  localparam int unsigned      FREE_W     = $clog2(PTX_DEPTH + 1),
  localparam int unsigned      QF_W       = $clog2(PQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              wake_evt,
  input  logic              sess_evt,
  input  logic              disc_evt,
  input  logic              cid_chg_evt,
  input  logic              sof_evt,
  input  logic              bus_rst_evt,
  input  logic [FREE_W-1:0] ptx_free_words,
  input  logic [QF_W-1:0]   ptx_q_free,
  input  logic              ptx_lvl_full,
  input  logic              np_tx_empty,
  input  logic              rx_nonempty,
  input  logic [31:0]       irq_mask,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  // Named internal events, exposed for the bound checker.
  logic [GS_W-1:0] evt_vec;
  logic [GS_W-1:0] gate_vec;
  logic [GS_W-1:0] set_vec;
  logic [GS_W-1:0] clr_vec;
  logic [GS_W-1:0] sticky_q;
  logic [GS_W-1:0] live_vec;
  logic [GS_W-1:0] st_raw;
  logic [GS_W-1:0] view;
  logic            ptx_hit;
  logic            ptxe_q, nptxe_q, rxlvl_q, mode_q;

  always_comb begin
    evt_vec           = '0;
    evt_vec[B_WAKE]   = wake_evt;
    evt_vec[B_SESS]   = sess_evt;
    evt_vec[B_DISC]   = disc_evt;
    evt_vec[B_CIDCHG] = cid_chg_evt;
    evt_vec[B_SOF]    = sof_evt;
    evt_vec[B_BUSRST] = bus_rst_evt;
  end

  // Role gating of event pulses, using the live mode input.
  assign gate_vec = ~(host_mode ? DEV_ONLY_MASK : HOST_ONLY_MASK);
  assign set_vec  = evt_vec & gate_vec & STICKY_MASK;

  gint_bus_port #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_bus (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .view_i(view),
    .clr_o(clr_vec), .rdata_o(reg_rdata)
  );

  for (genvar i = 0; i < GS_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      gint_sticky_bit u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]), .clr_i(clr_vec[i]),
        .q_o(sticky_q[i])
      );
    end else begin : g_none
      assign sticky_q[i] = 1'b0;
    end
  end

  gint_live_flags #(
    .PTX_DEPTH(PTX_DEPTH), .PQ_DEPTH(PQ_DEPTH), .FREE_W(FREE_W), .QF_W(QF_W)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .ptx_free_words(ptx_free_words), .ptx_q_free(ptx_q_free),
    .ptx_lvl_full(ptx_lvl_full), .np_tx_empty(np_tx_empty),
    .rx_nonempty(rx_nonempty), .ptx_hit_o(ptx_hit),
    .ptxe_q(ptxe_q), .nptxe_q(nptxe_q), .rxlvl_q(rxlvl_q), .mode_q(mode_q)
  );

  always_comb begin
    live_vec          = '0;
    live_vec[B_PTXE]  = ptxe_q;
    live_vec[B_NPTXE] = nptxe_q;
    live_vec[B_RXLVL] = rxlvl_q;
    live_vec[B_MODE]  = mode_q;
  end

  assign st_raw = sticky_q | live_vec;
  assign view   = role_view(st_raw, mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(view & irq_mask);
  end
endmodule

// File: rtl/gint_status_chk.sv
module gint_status_chk import usb_gint_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            host_mode,
  input logic [GS_W-1:0] set_vec,
  input logic [GS_W-1:0] clr_vec,
  input logic [GS_W-1:0] st_raw,
  input logic [GS_W-1:0] view,
  input logic [31:0]     irq_mask,
  input logic [31:0]     reg_rdata,
  input logic            irq
);
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0) |=> ((st_raw & $past(set_vec)) == $past(set_vec)));

  a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & STICKY_MASK & ~set_vec) != 0) |=>
      ((st_raw & $past(clr_vec & STICKY_MASK & ~set_vec)) == 0));

  a_r4_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != 0) |=>
      ((st_raw & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  a_r5_disc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !st_raw[B_DISC]) |=> !st_raw[B_DISC]);

  a_r6_busrst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && !st_raw[B_BUSRST]) |=> !st_raw[B_BUSRST]);

  a_r8_ptxe_device_low: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> !st_raw[B_PTXE]);

  a_r10_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~DEFINED_MASK) == 0));

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((view & irq_mask) == 0) |=> !irq);

  a_r11_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((view & irq_mask) != 0) |=> irq);
endmodule

bind usb_gint_status gint_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .set_vec(set_vec),
  .clr_vec(clr_vec), .st_raw(st_raw), .view(view), .irq_mask(irq_mask),
  .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/sim_usb_gint_status.sv
`timescale 1ns/1ps
module sim_usb_gint_status;
  localparam int DEPTH  = 16;
  localparam int QDEPTH = 4;
  localparam int FW     = $clog2(DEPTH + 1);
  localparam int QW     = $clog2(QDEPTH + 1);
  localparam logic [11:0] OFS = 12'h014;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b0;
  logic wake_evt = 0, sess_evt = 0, disc_evt = 0, cid_chg_evt = 0, sof_evt = 0, bus_rst_evt = 0;
  logic [FW-1:0] ptx_free_words = '0;
  logic [QW-1:0] ptx_q_free = '0;
  logic ptx_lvl_full = 1'b0;
  logic np_tx_empty = 1'b1;
  logic rx_nonempty = 1'b0;
  logic [31:0] irq_mask = '0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R12";

  always #2.5 clk = ~clk;

  usb_gint_status u0 (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .wake_evt(wake_evt),
    .sess_evt(sess_evt), .disc_evt(disc_evt), .cid_chg_evt(cid_chg_evt),
    .sof_evt(sof_evt), .bus_rst_evt(bus_rst_evt), .ptx_free_words(ptx_free_words),
    .ptx_q_free(ptx_q_free), .ptx_lvl_full(ptx_lvl_full), .np_tx_empty(np_tx_empty),
    .rx_nonempty(rx_nonempty), .irq_mask(irq_mask), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- reference model, from the requirements ----------------
  localparam logic [31:0] M_STICKY = 32'hF000_1008;  // R2: bits 31,30,29,28,12,3
  logic [31:0] m_sticky;
  logic m_mode, m_ptxe, m_np, m_rx, m_irq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_word(logic [31:0] stk, logic md, logic pt,
                                         logic np, logic rx);
    logic [31:0] w;
    w = stk;
    if (md)  w[12] = 1'b0;           // R6: device-only hidden in host
    else     w[29] = 1'b0;           // R5: host-only hidden in device
    w[26] = pt; w[5] = np; w[4] = rx; w[0] = md;
    return w;
  endfunction

  function automatic logic m_ptx(logic hm, int fr, int qf, logic full);
    int need;
    need = full ? DEPTH : DEPTH / 2;  // R8
    return hm && (qf > 0) && (fr >= need);
  endfunction

  function automatic logic [31:0] m_set(logic hm);
    logic [31:0] s;
    s = {wake_evt, sess_evt, disc_evt & hm, cid_chg_evt, 15'd0, bus_rst_evt & ~hm,
         8'd0, sof_evt, 3'd0};
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sticky <= '0; m_mode <= 0; m_ptxe <= 1; m_np <= 1; m_rx <= 0;
      m_rdata <= '0; m_irq <= 0;
    end else begin
      logic [31:0] clr, w;
      clr = (reg_sel && reg_wr && reg_addr == OFS) ? (reg_wdata & M_STICKY) : '0;
      w = m_word(m_sticky, m_mode, m_ptxe, m_np, m_rx);
      m_sticky <= m_set(host_mode) | (m_sticky & ~clr);
      m_mode <= host_mode;
      m_ptxe <= m_ptx(host_mode, int'(ptx_free_words), int'(ptx_q_free), ptx_lvl_full);
      m_np <= np_tx_empty;
      m_rx <= rx_nonempty;
      m_rdata <= (reg_sel && !reg_wr && reg_addr == OFS) ? w : '0;
      m_irq <= |(w & irq_mask);
    end
  end

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Continuous comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check32("R12", reg_rdata, m_rdata);
      check32("R11", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic idle();
    wake_evt = 0; sess_evt = 0; disc_evt = 0; cid_chg_evt = 0; sof_evt = 0; bus_rst_evt = 0;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); idle(); reg_sel = 1; reg_wr = 0; reg_addr = OFS;
    @(negedge clk); idle(); d = reg_rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk); idle(); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic pulse(logic w, logic s, logic d, logic c, logic f, logic b);
    @(negedge clk); idle();
    wake_evt = w; sess_evt = s; disc_evt = d; cid_chg_evt = c; sof_evt = f; bus_rst_evt = b;
    @(negedge clk); idle();
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    // R1: read issued while reset releases returns the reset word.
    reg_sel = 1; reg_wr = 0; reg_addr = OFS;
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk); idle();
    check32("R1", reg_rdata, 32'h0400_0020);
    check32("R1", {31'd0, irq}, 32'd0);

    // R5/R6 in device mode
    pulse(0, 0, 1, 0, 0, 0);
    rd(d); check32("R5", d & 32'h2000_0000, 32'h0);
    pulse(0, 0, 0, 0, 0, 1);
    rd(d); check32("R6", d & 32'h0000_1000, 32'h0000_1000);

    // host mode
    @(negedge clk); host_mode = 1; wait_cyc(2);
    rd(d); check32("R10", d & 32'h0000_1001, 32'h0000_0001);
    pulse(0, 0, 1, 0, 0, 1);
    rd(d); check32("R5", d & 32'h2000_0000, 32'h2000_0000);
    pulse(1, 1, 0, 1, 1, 0);
    rd(d); check32("R7", d & 32'hD000_0008, 32'hD000_0008);

    // R2 write zero, R3 wrong offset, then targeted clear
    wr(OFS, 32'h0);
    rd(d); check32("R2", d & 32'hF000_0008, 32'hF000_0008);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(d); check32("R3", d & 32'hF000_0008, 32'hF000_0008);
    wr(OFS, 32'h2000_0000);
    rd(d); check32("R3", d & 32'hF000_0008, 32'hD000_0008);

    // R4 event and clear together
    @(negedge clk); idle(); disc_evt = 1; reg_sel = 1; reg_wr = 1; reg_addr = OFS;
    reg_wdata = 32'h2000_0000;
    @(negedge clk); idle();
    rd(d); check32("R4", d & 32'h2000_0000, 32'h2000_0000);

    // R8 threshold corners
    @(negedge clk); ptx_q_free = 1; ptx_lvl_full = 0; ptx_free_words = FW'(DEPTH/2);
    wait_cyc(1); rd(d); check32("R8", d & 32'h0400_0000, 32'h0400_0000);
    ptx_free_words = FW'(DEPTH/2 - 1);
    wait_cyc(1); rd(d); check32("R8", d & 32'h0400_0000, 32'h0);
    ptx_lvl_full = 1; ptx_free_words = FW'(DEPTH - 1);
    wait_cyc(1); rd(d); check32("R8", d & 32'h0400_0000, 32'h0);
    ptx_free_words = FW'(DEPTH);
    wait_cyc(1); rd(d); check32("R8", d & 32'h0400_0000, 32'h0400_0000);
    ptx_q_free = 0;
    wait_cyc(1); rd(d); check32("R8", d & 32'h0400_0000, 32'h0);

    // R9 live flags ignore writes; R10 bit 27 stays low
    @(negedge clk); np_tx_empty = 0; rx_nonempty = 1;
    wait_cyc(1);
    wr(OFS, 32'h0800_0030);
    rd(d); check32("R9", d & 32'h0000_0030, 32'h0000_0010);
    check32("R10", d & 32'h0800_0000, 32'h0);

    // R11 mask
    @(negedge clk); irq_mask = 32'h8000_0000; wait_cyc(2);
    check32("R11", {31'd0, irq}, 32'd1);
    irq_mask = 32'h0000_0100; wait_cyc(2);
    check32("R11", {31'd0, irq}, 32'd0);

    // Constrained random phase, fixed seed.
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); idle();
      if ($urandom_range(0, 49) == 0) host_mode = ~host_mode;
      wake_evt    = ($urandom_range(0, 9) == 0);
      sess_evt    = ($urandom_range(0, 9) == 0);
      disc_evt    = ($urandom_range(0, 5) == 0);
      cid_chg_evt = ($urandom_range(0, 9) == 0);
      sof_evt     = ($urandom_range(0, 3) == 0);
      bus_rst_evt = ($urandom_range(0, 5) == 0);
      ptx_free_words = FW'($urandom_range(0, DEPTH));
      ptx_q_free     = QW'($urandom_range(0, QDEPTH));
      ptx_lvl_full   = $urandom_range(0, 1) == 1;
      np_tx_empty    = $urandom_range(0, 1) == 1;
      rx_nonempty    = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) irq_mask = $urandom();
      if ($urandom_range(0, 2) == 0) begin
        reg_sel = 1; reg_wr = $urandom_range(0, 1) == 1;
        reg_addr = ($urandom_range(0, 7) == 0) ? 12'h010 : OFS;
        reg_wdata = $urandom();
      end
    end
    @(negedge clk); idle();
    wait_cyc(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule